// File: doc/BRIEF.md
# Diagonal Wavefront Voltage Boost Controller

This block picks, cycle by cycle, which anti-diagonal groups of processing elements in a square weight-stationary systolic array are switched onto the high supply rail. In such an array the activation wavefront sweeps diagonally. All elements on one anti-diagonal start computing in the same cycle and stop in the same cycle. A boost therefore only pays off on the diagonals that the wavefront currently covers.

Each cycle the controller receives the running cycle number, a boost-enable flag and a predicted window given as an inclusive low and high cycle. It also keeps a per-diagonal enable mask. A diagonal gets the boost rail only when four things hold: boosting is enabled, the cycle lies inside the window, the diagonal is computing, and its mask bit is set. In every other case the diagonal stays on the near-threshold rail. The decision is registered and drives the rails for exactly one cycle. After that the rail falls back unless the next decision boosts it again. Configuration writes one mask bit at a time through an address, data and write-enable port.

Top module: `wave_boost_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, every `rail_sel` bit becomes 0 (near-threshold rail) and every mask bit becomes 1.
- R2: When `boost_init` is 0 in cycle c, all `rail_sel` bits are 0 in cycle c+1.
- R3: The boost window is inclusive at both ends. A cycle number below `win_lo` or above `win_hi` gives all-zero `rail_sel` in the next cycle. When `win_lo` is greater than `win_hi` the window is empty.
- R4: Diagonal d (bit d of `rail_sel`, for d from 0 to 2·ARR_N−2) is computing when `cycle_num − d` lies in 0..STREAM_LEN−1. A diagonal that is not computing is never boosted.
- R5: A diagonal whose mask bit is 0 is never boosted.
- R6: `rail_sel` is registered. A decision made from the inputs in cycle c appears in cycle c+1. Each bit holds for one cycle only and is recomputed every cycle.
- R7: When `cfg_we` is 1, the mask bit at `cfg_addr` takes the value `cfg_bit`. The new value governs decisions from the next cycle on. A write to an address of 2·ARR_N−1 or more changes no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_num | input | CYC_W | Current operational cycle number |
| boost_init | input | 1 | Boosting allowed for this operation |
| win_lo | input | CYC_W | First cycle of the boost window (inclusive) |
| win_hi | input | CYC_W | Last cycle of the boost window (inclusive) |
| cfg_we | input | 1 | Mask bit write strobe |
| cfg_addr | input | $clog2(2·ARR_N−1) | Diagonal index of the mask bit to write |
| cfg_bit | input | 1 | Value written to the addressed mask bit |
| rail_sel | output | 2·ARR_N−1 | Per-diagonal rail select, 1 = boost rail, 0 = near-threshold rail |

## Verification
The assertions assume that `rst` is driven to a known level from the first clock edge on. They also assume that `cycle_num`, `win_lo` and `win_hi` are stable, known values at each edge, because each property compares the output with the inputs sampled one edge earlier. The bench changes every input only on the falling clock edge and holds reset for several cycles at start-up, so these assumptions always hold. The window and activity vectors stay inside the cycle width, and out-of-range mask addresses are applied on purpose to check that they are ignored.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic {
        RAIL_LOW   = 1'b0,
        RAIL_BOOST = 1'b1
    } rail_e;

    // diagonal d is computing when 0 <= c - d < len
    function automatic logic diag_live(input int unsigned c,
                                       input int unsigned d,
                                       input int unsigned len);
        return (c >= d) && ((c - d) < len);
    endfunction

    function automatic logic in_window(input int unsigned c,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (lo <= c) && (c <= hi);
    endfunction

endpackage

// File: rtl/wbc_mask_reg.sv
module wbc_mask_reg #(
    parameter int NDIAG = 31,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic             wbit,
    output logic [NDIAG-1:0] mask
);
    localparam logic [AW:0] LIMIT = (AW+1)'(NDIAG);

    logic [NDIAG-1:0] mask_q;
    logic             addr_ok;

    assign addr_ok = ({1'b0, addr} < LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (we && addr_ok) begin
            mask_q[addr] <= wbit;
        end
    end

    assign mask = mask_q;

    // R7: an accepted write lands in the addressed bit
    p_mask_write_r7: assert property (@(posedge clk) disable iff (rst)
        (we && addr_ok) |=> (mask[$past(addr)] == $past(wbit)));

    // R7: a write outside the diagonal range leaves the mask alone
    p_mask_oob_r7: assert property (@(posedge clk) disable iff (rst)
        (we && !addr_ok) |=> $stable(mask));

    // R1: reset fills the mask with ones
    p_mask_reset_r1: assert property (@(posedge clk)
        rst |=> (mask == '1));

endmodule

// File: rtl/wbc_diag_decode.sv
module wbc_diag_decode #(
    parameter int NDIAG      = 31,
    parameter int STREAM_LEN = 16,
    parameter int CYC_W      = 8
) (
    input  logic [CYC_W-1:0] cycle_num,
    output logic [NDIAG-1:0] active
);
    for (genvar g = 0; g < NDIAG; g++) begin : g_diag
        assign active[g] = wbc_pkg::diag_live(32'(cycle_num), 32'(g),
                                              32'(STREAM_LEN));
    end

    // R4: the wavefront never covers more diagonals than the stream length
    always_comb begin
        a_width_r4: assert ($countones(active) <= STREAM_LEN);
    end

endmodule

// File: rtl/wbc_rail_sel.sv
module wbc_rail_sel #(
    parameter int NDIAG = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_ok,
    input  logic [NDIAG-1:0] active,
    input  logic [NDIAG-1:0] mask,
    output logic [NDIAG-1:0] rail_sel
);
    import wbc_pkg::*;

    rail_e sel_q [NDIAG];

    for (genvar g = 0; g < NDIAG; g++) begin : g_rail
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[g] <= RAIL_LOW;
            end else if (win_ok && active[g] && mask[g]) begin
                sel_q[g] <= RAIL_BOOST;
            end else begin
                sel_q[g] <= RAIL_LOW;
            end
        end
        assign rail_sel[g] = (sel_q[g] == RAIL_BOOST);
    end

    // R1: reset drops every diagonal to the near-threshold rail
    p_rail_reset_r1: assert property (@(posedge clk)
        rst |=> (rail_sel == '0));

    // R4: only diagonals that were computing may be boosted
    p_only_active_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rail_sel & ~$past(active)) == '0));

    // R5: masked diagonals stay low
    p_masked_low_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rail_sel & ~$past(mask)) == '0));

    // R6: a qualifying diagonal is boosted exactly one cycle later
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        win_ok |=> (rail_sel == $past(active & mask)));

endmodule

// File: rtl/wave_boost_ctrl.sv
module wave_boost_ctrl #(
    parameter int ARR_N      = 16,
    parameter int STREAM_LEN = ARR_N,
    parameter int CYC_W      = 8,
    localparam int NDIAG     = 2 * ARR_N - 1,
    localparam int AW        = $clog2(NDIAG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CYC_W-1:0] cycle_num,
    input  logic             boost_init,
    input  logic [CYC_W-1:0] win_lo,
    input  logic [CYC_W-1:0] win_hi,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic             cfg_bit,
    output logic [NDIAG-1:0] rail_sel
);
    logic [NDIAG-1:0] mask;
    logic [NDIAG-1:0] active;
    logic             win_ok;

    assign win_ok = boost_init &&
                    wbc_pkg::in_window(32'(cycle_num), 32'(win_lo), 32'(win_hi));

    wbc_mask_reg #(.NDIAG(NDIAG), .AW(AW)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wbit (cfg_bit),
        .mask (mask)
    );

    wbc_diag_decode #(.NDIAG(NDIAG), .STREAM_LEN(STREAM_LEN), .CYC_W(CYC_W)) u_dec (
        .cycle_num (cycle_num),
        .active    (active)
    );

    wbc_rail_sel #(.NDIAG(NDIAG)) u_rail (
        .clk      (clk),
        .rst      (rst),
        .win_ok   (win_ok),
        .active   (active),
        .mask     (mask),
        .rail_sel (rail_sel)
    );

    // R2: boosting disabled means every rail is low next cycle
    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        !boost_init |=> (rail_sel == '0));

    // R3: a cycle outside the window boosts nothing
    p_outside_low_r3: assert property (@(posedge clk) disable iff (rst)
        ((cycle_num < win_lo) || (cycle_num > win_hi)) |=> (rail_sel == '0));

endmodule

// File: tb/sim_wave_boost_ctrl.sv
module sim_wave_boost_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int ND = 2 * N - 1;   // 7 diagonals
    localparam int AW = 3;

    typedef struct packed {
        logic [7:0]    cyc;
        logic          init;
        logic [7:0]    lo;
        logic [7:0]    hi;
        logic [ND-1:0] exp;
        logic [7:0]    req;
    } vec_t;

    // diagonal d is computing when cyc - d is in 0..3; mask all ones
    localparam vec_t TBL [12] = '{
        '{8'd0,  1'b1, 8'd0, 8'd10, 7'b0000001, 8'd4},  // R4 first diagonal only
        '{8'd3,  1'b1, 8'd0, 8'd10, 7'b0001111, 8'd4},  // R4 full wavefront
        '{8'd5,  1'b1, 8'd0, 8'd10, 7'b0111100, 8'd4},  // R4 middle
        '{8'd6,  1'b1, 8'd0, 8'd10, 7'b1111000, 8'd4},  // R4 reaches last diagonal
        '{8'd9,  1'b1, 8'd0, 8'd10, 7'b1000000, 8'd4},  // R4 tail
        '{8'd10, 1'b1, 8'd0, 8'd10, 7'b0000000, 8'd4},  // R4 drained
        '{8'd4,  1'b0, 8'd0, 8'd10, 7'b0000000, 8'd2},  // R2 disabled
        '{8'd4,  1'b1, 8'd5, 8'd8,  7'b0000000, 8'd3},  // R3 below window
        '{8'd5,  1'b1, 8'd5, 8'd8,  7'b0111100, 8'd3},  // R3 low edge inclusive
        '{8'd8,  1'b1, 8'd5, 8'd8,  7'b1100000, 8'd3},  // R3 high edge inclusive
        '{8'd9,  1'b1, 8'd5, 8'd8,  7'b0000000, 8'd3},  // R3 above window
        '{8'd3,  1'b1, 8'd6, 8'd2,  7'b0000000, 8'd3}   // R3 inverted window empty
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    cycle_num = '0;
    logic          boost_init = 1'b0;
    logic [7:0]    win_lo = '0;
    logic [7:0]    win_hi = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_bit = 1'b0;
    logic [ND-1:0] rail_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_boost_ctrl #(.ARR_N(N), .STREAM_LEN(N), .CYC_W(8)) u0 (
        .clk(clk), .rst(rst), .cycle_num(cycle_num), .boost_init(boost_init),
        .win_lo(win_lo), .win_hi(win_hi), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_bit(cfg_bit), .rail_sel(rail_sel)
    );

    task automatic check(input int req, input logic [ND-1:0] got,
                         input logic [ND-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d got=%b exp=%b", req, got, exp);
        end
    endtask

    // drive on falling edge, sample just after the next rising edge
    task automatic step(input logic [7:0] c, input logic i,
                        input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        cycle_num = c; boost_init = i; win_lo = lo; win_hi = hi;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic b);
        @(negedge clk);
        boost_init = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_bit = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(1, rail_sel, '0);                // R1 reset state
        @(negedge clk);
        rst = 1'b0;

        foreach (TBL[k]) begin
            step(TBL[k].cyc, TBL[k].init, TBL[k].lo, TBL[k].hi);
            check(int'(TBL[k].req), rail_sel, TBL[k].exp);
        end

        // R6: output holds the old decision until the next edge, then drops
        step(8'd3, 1'b1, 8'd0, 8'd10);
        check(6, rail_sel, 7'b0001111);
        @(negedge clk);
        cycle_num = 8'd20;
        #1;
        check(6, rail_sel, 7'b0001111);        // R6 not yet updated
        @(posedge clk);
        #1;
        check(6, rail_sel, 7'b0000000);        // R6 one-cycle boost only

        // R5: clear mask bit 3
        wr(3'd3, 1'b0);
        step(8'd3, 1'b1, 8'd0, 8'd10);
        check(5, rail_sel, 7'b0000111);
        // R7: out-of-range address 7 ignored
        wr(3'd7, 1'b0);
        step(8'd6, 1'b1, 8'd0, 8'd10);
        check(7, rail_sel, 7'b1110000);
        // R7: write lands only from the next decision on
        @(negedge clk);
        cycle_num = 8'd0; boost_init = 1'b1; win_lo = 8'd0; win_hi = 8'd10;
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_bit = 1'b0;
        @(posedge clk);
        #1;
        check(7, rail_sel, 7'b0000001);        // R7 old mask used
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk);
        #1;
        check(7, rail_sel, 7'b0000000);        // R7 bit 0 now cleared
        // R1: reset restores an all-ones mask
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1, rail_sel, '0);
        @(negedge clk);
        rst = 1'b0;
        step(8'd3, 1'b1, 8'd0, 8'd10);
        check(1, rail_sel, 7'b0001111);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule